// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

The block decides the ordering of two words, P and Q, and reports it on two decision outputs: one for P greater than Q and one for P less than Q. When neither output is high, the words are equal. A mode input chooses how the words are read. They can be treated as unsigned binary numbers or as two's complement numbers. The full word is built from a parameterised number of 8-bit lanes. The lanes form a ripple chain that runs from the least significant lane to the most significant one. A lane whose two slices differ decides the result on its own. A lane whose slices are equal passes on the decision it receives from the lane below.

The bottom of the chain takes two cascade inputs. This lets the block sit above a narrower comparator that handles still less significant bits. When nothing sits below it, the user ties both cascade inputs low, and equal words then give both outputs low.

The P operand passes through a holding stage. While the latch enable is high, the current P input reaches the compare logic directly. On each clock edge with the enable high, that value is also stored. While the enable is low, the compare logic uses the stored value instead. Q is never stored. The compare logic always takes Q straight from its input.

Top module: `magcmp_cascade`

## Requirements
- R1: With `mode_signed` low and the effective P different from Q, `gt_o` is high exactly when P > Q as unsigned numbers of width 8×LANES, and `lt_o` is its complement.
- R2: With `mode_signed` high and the words different, `gt_o`/`lt_o` follow the two's complement ordering. Only bit 8×LANES−1, the top bit of the most significant lane, is a sign bit. All lower lanes compare as unsigned.
- R3: When the effective P equals Q, `gt_o` equals `cin_gt` and `lt_o` equals `cin_lt`. With both cascade inputs low, equal words give `gt_o`=0 and `lt_o`=0.
- R4: When the words differ, the cascade inputs have no effect on `gt_o`/`lt_o`.
- R5: When the cascade inputs are not both high, `gt_o` and `lt_o` are never high together.
- R6: While `p_le` is high, the compare uses the present `p_word` in the same cycle, with no clock edge needed.
- R7: Each rising clock edge with `p_le` high stores `p_word`. While `p_le` is low, the compare uses the stored value, and changes on `p_word` have no effect.
- R8: An active-low `rst_n` clears the stored P value to zero.
- R9: Q is never stored. A change on `q_word` reaches the outputs in the same cycle, whatever the value of `p_le`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that captures the P operand |
| rst_n | input | 1 | Asynchronous active-low reset of the stored P |
| mode_signed | input | 1 | 1 = two's complement compare, 0 = unsigned |
| p_le | input | 1 | P enable: 1 = pass P through and store it, 0 = hold |
| p_word | input | 8×LANES | P operand |
| q_word | input | 8×LANES | Q operand, never stored |
| cin_gt | input | 1 | Greater-than decision from a less significant comparator |
| cin_lt | input | 1 | Less-than decision from a less significant comparator |
| gt_o | output | 1 | P greater than Q |
| lt_o | output | 1 | P less than Q |

## Verification
On every cycle, the bound checker compares the outputs against a whole-word compare, signed or unsigned, of the effective P and Q. It also checks that equal words pass the cascade inputs through, that the lane equality flags agree with whole-word equality, that the two outputs are mutually exclusive, and that the effective P stays fixed while the enable is low. Some behaviours can only be shown by the bench's scenarios. These are the value that reset leaves in the holding stage, that a P change during hold is invisible at the outputs, and that Q changes during hold still show up at once. The scenarios also cover corner operands at the lane and sign boundaries, with the cascade inputs forced to conflicting values.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic gt;
    logic lt;
  } dec_t;

  // Order two lane slices; when sgn is set the top bit is a sign bit,
  // handled by inverting it so that an unsigned compare gives signed order.
  function automatic dec_t lane_decide(input logic [LANE_W-1:0] p,
                                       input logic [LANE_W-1:0] q,
                                       input logic sgn);
    logic [LANE_W-1:0] bias;
    logic [LANE_W-1:0] pb;
    logic [LANE_W-1:0] qb;
    dec_t d;
    bias = {sgn, {(LANE_W-1){1'b0}}};
    pb = p ^ bias;
    qb = q ^ bias;
    d.gt = (pb > qb);
    d.lt = (pb < qb);
    return d;
  endfunction

  // A lane that sees equal slices defers to the decision from below.
  function automatic dec_t merge(input dec_t local_d, input logic same,
                                 input dec_t below);
    return same ? below : local_d;
  endfunction

endpackage

// File: rtl/magcmp_oplatch.sv
module magcmp_oplatch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (le) held <= d;
  end

  // Pass-through while enabled gives latch-like transparency without a latch.
  assign q = le ? d : held;
endmodule

// File: rtl/magcmp_lane.sv
module magcmp_lane
  import magcmp_pkg::*;
#(
  parameter bit SIGN_LANE = 1'b0
) (
  input  logic              mode_signed,
  input  logic [LANE_W-1:0] p,
  input  logic [LANE_W-1:0] q,
  input  dec_t              below,
  output dec_t              dout,
  output logic              same
);
  logic sgn;
  dec_t local_d;

  assign sgn     = mode_signed & SIGN_LANE;
  assign local_d = lane_decide(p, q, sgn);
  assign same    = (p == q);
  assign dout    = merge(local_d, same, below);
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    mode_signed,
  input  logic [LANES*LANE_W-1:0] p,
  input  logic [LANES*LANE_W-1:0] q,
  input  dec_t                    cin,
  output dec_t                    dout,
  output logic [LANES-1:0]        lane_eq
);
  dec_t link [LANES+1];

  assign link[0] = cin;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    magcmp_lane #(.SIGN_LANE(i == LANES-1)) u_lane (
      .mode_signed(mode_signed),
      .p          (p[i*LANE_W +: LANE_W]),
      .q          (q[i*LANE_W +: LANE_W]),
      .below      (link[i]),
      .dout       (link[i+1]),
      .same       (lane_eq[i])
    );
  end

  assign dout = link[LANES];
endmodule

// File: rtl/magcmp_cascade.sv
module magcmp_cascade
  import magcmp_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned W = LANES * LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_signed,
  input  logic         p_le,
  input  logic [W-1:0] p_word,
  input  logic [W-1:0] q_word,
  input  logic         cin_gt,
  input  logic         cin_lt,
  output logic         gt_o,
  output logic         lt_o
);
  logic [W-1:0]     p_eff;
  logic [LANES-1:0] lane_eq;
  dec_t             cin_d;
  dec_t             res;

  assign cin_d = '{gt: cin_gt, lt: cin_lt};

  magcmp_oplatch #(.W(W)) u_plat (
    .clk  (clk),
    .rst_n(rst_n),
    .le   (p_le),
    .d    (p_word),
    .q    (p_eff)
  );

  magcmp_chain #(.LANES(LANES)) u_chain (
    .mode_signed(mode_signed),
    .p          (p_eff),
    .q          (q_word),
    .cin        (cin_d),
    .dout       (res),
    .lane_eq    (lane_eq)
  );

  assign gt_o = res.gt;
  assign lt_o = res.lt;
endmodule

// File: rtl/magcmp_cascade_chk.sv
module magcmp_cascade_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_signed,
  input logic             p_le,
  input logic [W-1:0]     p_eff,
  input logic [W-1:0]     q_word,
  input logic [LANES-1:0] lane_eq,
  input logic             cin_gt,
  input logic             cin_lt,
  input logic             gt_o,
  input logic             lt_o
);
  p_unsigned_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_signed && p_eff != q_word) |-> (gt_o == (p_eff > q_word) && lt_o == (p_eff < q_word)));

  p_signed_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_signed && p_eff != q_word) |->
      (gt_o == ($signed(p_eff) > $signed(q_word)) && lt_o == ($signed(p_eff) < $signed(q_word))));

  p_equal_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_eff == q_word) |-> (gt_o == cin_gt && lt_o == cin_lt));

  p_lane_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_eq) == (p_eff == q_word));

  p_differ_decides_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_eff != q_word) |-> (gt_o != lt_o));

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cin_gt && cin_lt) |-> !(gt_o && lt_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_le && $past(rst_n)) |-> (p_eff == $past(p_eff)));
endmodule

bind magcmp_cascade magcmp_cascade_chk #(.W(W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_signed(mode_signed),
  .p_le       (p_le),
  .p_eff      (p_eff),
  .q_word     (q_word),
  .lane_eq    (lane_eq),
  .cin_gt     (cin_gt),
  .cin_lt     (cin_lt),
  .gt_o       (gt_o),
  .lt_o       (lt_o)
);

// File: tb/test_magcmp_cascade.sv
module test_magcmp_cascade;
  localparam int unsigned LANES = 4;
  localparam int unsigned W = LANES * 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_signed = 1'b0;
  logic         p_le = 1'b0;
  logic [W-1:0] p_word = '0;
  logic [W-1:0] q_word = '0;
  logic         cin_gt = 1'b0;
  logic         cin_lt = 1'b0;
  logic         gt_o, lt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  gt;
    logic  lt;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench model of the stored P
  logic [W-1:0] held_m = '0;
  logic [W-1:0] last_p = '0;
  logic         last_le = 1'b0;

  always #5 clk = ~clk;

  magcmp_cascade #(.LANES(LANES)) i_magcmp_cascade (
    .clk(clk), .rst_n(rst_n), .mode_signed(mode_signed), .p_le(p_le),
    .p_word(p_word), .q_word(q_word), .cin_gt(cin_gt), .cin_lt(cin_lt),
    .gt_o(gt_o), .lt_o(lt_o)
  );

  function automatic exp_t model(input logic [W-1:0] pe, input logic [W-1:0] q,
                                 input logic sm, input logic cg, input logic cl,
                                 input string tag);
    exp_t e;
    e.tag = tag;
    if (pe == q) begin
      e.gt = cg; e.lt = cl;
    end else begin
      // signed order: flip the top bit so unsigned compare orders signed values
      if (sm) e.gt = ((pe ^ (1 << (W-1))) > (q ^ (1 << (W-1))));
      else    e.gt = (pe > q);
      e.lt = !e.gt;
    end
    return e;
  endfunction

  // driver: one stimulus per cycle, applied on the falling edge
  task automatic drive(input logic [W-1:0] p, input logic [W-1:0] q, input logic sm,
                       input logic le, input logic cg, input logic cl, input string tag);
    logic [W-1:0] pe;
    @(negedge clk);
    if (last_le) held_m = last_p;
    p_word = p; q_word = q; mode_signed = sm; p_le = le; cin_gt = cg; cin_lt = cl;
    pe = le ? p : held_m;
    sb.push_back(model(pe, q, sm, cg, cl, tag));
    last_p = p; last_le = le;
  endtask

  // monitor: samples 4 ns after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (gt_o !== e.gt || lt_o !== e.lt) begin
          failures++;
          $display("FAIL %s: gt/lt=%b%b expected %b%b (p=%h q=%h)",
                   e.tag, gt_o, lt_o, e.gt, e.lt, p_word, q_word);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    held_m = '0; last_le = 1'b0;

    // R8: stored P is zero after reset
    drive(32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset zero eq");
    drive(32'hDEAD_BEEF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset zero lt");
    // R9: q moves during hold and reaches outputs in the same cycle
    drive(32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R9 q in hold");

    // R6: transparent pass-through
    drive(32'h0000_0005, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 1'b0, "R6 transparent gt");
    drive(32'h0000_0003, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 1'b0, "R6 transparent lt");

    // R1 unsigned corners
    drive(32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 all ones vs zero");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R1 sign boundary");
    drive(32'h0100_0000, 32'h00FF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R1 lane boundary");
    drive(32'h1111_1100, 32'h1111_1101, 1'b0, 1'b1, 1'b0, 1'b0, "R1 low lane only");
    drive(32'h0000_0080, 32'h0000_007F, 1'b1, 1'b1, 1'b0, 1'b0, "R2 lower lane unsigned");
    // R2 signed corners
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 minus one vs zero");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R2 min vs max");
    drive(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R2 both negative");

    // R3 equal words, cascade passes through
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R3 equal ones");
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0, "R3 equal cin gt");
    drive(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, "R3 equal cin lt");
    drive(32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1, 1'b1, 1'b1, 1'b1, "R3 equal cin both");

    // R4 differing words ignore opposing cascade
    drive(32'h0000_0002, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b1, "R4 gt over cin lt");
    drive(32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1, 1'b1, 1'b0, "R4 lt over cin gt");
    drive(32'h7F00_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, "R4 signed over cin");

    // R7 hold: store A, then change p while disabled
    drive(32'h4242_4242, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 load");
    drive(32'h0000_0000, 32'h4242_4242, 1'b0, 1'b0, 1'b0, 1'b0, "R7 held eq");
    drive(32'hFFFF_FFFF, 32'h4242_4243, 1'b0, 1'b0, 1'b0, 1'b0, "R7 held lt");
    drive(32'h0000_0000, 32'h4242_4241, 1'b1, 1'b0, 1'b0, 1'b0, "R7 held gt");
    drive(32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R7 reopen");

    // R1/R2/R5 random sweep, enable toggling
    for (int i = 0; i < 200; i++) begin
      a = $urandom();
      b = (i % 5 == 0) ? a ^ (32'h1 << (i % W)) : $urandom();
      drive(a, b, i[0], i[1] | i[2], 1'b0, 1'b0, i[0] ? "R2 random" : "R1 random");
    end

    @(negedge clk);
    #6;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule